// File: doc/BRIEF.md
# Split-Tree Oblivious RAM Host Sequencer

This block sits on the host side of an oblivious RAM whose tree is cut into two halves, each kept by its own memory-module engine. A requester hands it one logical read or write at a time. The block looks up the block's current leaf in its leaf table. The top bit of that leaf names the module that holds the block. The block then drives a command channel to the modules and gathers their replies on a response channel.

The path reads and writes are done inside the module. The host only takes four steps. It starts the access on the owning module, polls that module until the module reports it has finished, and collects the block. It then broadcasts a relocation command that carries the block and a freshly drawn leaf. The module whose half contains the new leaf takes the block in, and the other module drops the command. New leaves come from an internal LFSR. If a module never finishes, polling gives up after a fixed number of attempts and the requester receives an error.

Top module: `oram_split_host`

## Requirements
- R1: After reset every address maps to the leaf equal to the low 4 bits of the address. The most significant leaf bit picks the module: 0 gives `cmd_sel` 2'b01 and 1 gives `cmd_sel` 2'b10.
- R2: An accepted request first emits a start command to the owning module only. It carries opcode 4'h1 for a read or 4'h9 for a write, the address in `cmd_addr` and the write data in `cmd_data`.
- R3: After the start, poll commands (opcode 4'h2) go to the same module, one per module response, until a response arrives with `mod_rsp_done` high.
- R4: After the done response, one collect command (opcode 4'h3) goes to the same module. The data returned for a read, or the write data for a write, appears on `rsp_rdata` with `rsp_err` low.
- R5: The request ends with a relocate command (opcode 4'h4) sent to both modules (`cmd_sel` 2'b11). It carries the address, the block data and the new leaf in `cmd_leaf`. `rsp_valid` is high in the same cycle.
- R6: New leaves come from an 8-bit LFSR with seed 8'h01 and next state {s[6:0], s[7]^s[5]^s[4]^s[3]}. The leaf is the low 4 bits of the state before the step. The LFSR steps once per relocate, and the leaf table takes the new leaf so that the next request to that address routes by it.
- R7: When 64 polls in a row get no done response, `rsp_valid` rises with `rsp_err` high. No collect or relocate follows, and neither the leaf table nor the LFSR changes.
- R8: `req_ready` stays low from acceptance until the cycle in which the relocate command or the error response is presented.
- R9: During and right after reset, `req_ready` is high while `cmd_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Logical block address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Poll limit reached |
| rsp_rdata | output | 32 | Block data for the requester |
| cmd_valid | output | 1 | Command present this cycle |
| cmd_op | output | 4 | Command opcode |
| cmd_sel | output | 2 | One-hot module select, all ones for broadcast |
| cmd_addr | output | 8 | Command address field |
| cmd_data | output | 32 | Command data field |
| cmd_leaf | output | 4 | Leaf field (current leaf, or new leaf on relocate) |
| mod_rsp_valid | input | 1 | Module response present |
| mod_rsp_done | input | 1 | Poll response: module finished |
| mod_rsp_data | input | 32 | Collect response: block data |

## Verification
The hardest case to reach is a block that has been moved by a relocate and then hit by a timeout. The route for a later request depends on both the leaf table and how far the LFSR has advanced. The bench writes every address of a 16-address window and reads each one back several times, so every block moves across the halves in a pattern the bench predicts from the LFSR formula. Between these passes, a module model that never reports done forces a timeout. The following request to the same address must go to the unchanged module and receive the next unused leaf.

// File: rtl/oram_host_pkg.sv
package oram_host_pkg;
  typedef enum logic [3:0] {
    OP_NONE     = 4'h0,
    OP_START_RD = 4'h1,
    OP_POLL     = 4'h2,
    OP_COLLECT  = 4'h3,
    OP_RELOCATE = 4'h4,
    OP_START_WR = 4'h9
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_POLL,
    ST_WAIT_POLL,
    ST_COLLECT,
    ST_WAIT_COLLECT,
    ST_RELOCATE
  } seq_state_e;
endpackage

// File: rtl/oram_host_leaf_table.sv
module oram_host_leaf_table #(
  parameter int ADDR_W = 8,
  parameter int LEAF_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LEAF_W-1:0] rd_leaf,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEAF_W-1:0] wr_leaf
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LEAF_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [LEAF_W-1:0] mem_rd_q;
  logic [LEAF_W-1:0] dflt_q;
  logic              hit_q;

  // RAM part: no reset, one write port, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_leaf;
    if (rd_en) mem_rd_q <= mem[rd_addr];
  end

  // Written-flags and default leaf in flops so reset covers them
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      hit_q  <= 1'b0;
      dflt_q <= '0;
    end else begin
      if (wr_en) vld_q[wr_addr] <= 1'b1;
      if (rd_en) begin
        hit_q  <= vld_q[rd_addr];
        dflt_q <= LEAF_W'(rd_addr);
      end
    end
  end

  assign rd_leaf = hit_q ? mem_rd_q : dflt_q;

  // R6
  wr_marks_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_addr)]);
endmodule

// File: rtl/oram_host_lfsr.sv
module oram_host_lfsr #(
  parameter int            LFSR_W = 8,
  parameter logic [7:0]    TAPS   = 8'hB8,
  parameter int            LEAF_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [LEAF_W-1:0] leaf
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb   = ^(state_q & LFSR_W'(TAPS));
  assign leaf = state_q[LEAF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       state_q <= LFSR_W'(1);
    else if (step) state_q <= {state_q[LFSR_W-2:0], fb};
  end

  // R6
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R7
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(step) && !$past(rst) |-> $stable(state_q));
endmodule

// File: rtl/oram_host_route_dec.sv
module oram_host_route_dec #(
  parameter int NUM_MOD = 2,
  parameter int IDX_W   = 1
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_MOD-1:0] sel
);
  for (genvar i = 0; i < NUM_MOD; i++) begin : g_sel
    assign sel[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/oram_split_host.sv
module oram_split_host #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 32,
  parameter int         LEAF_W    = 4,
  parameter int         NUM_MOD   = 2,
  parameter int         PROBE_MAX = 64,
  parameter int         LFSR_W    = 8,
  parameter logic [7:0] LFSR_TAPS = 8'hB8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               cmd_valid,
  output logic [3:0]         cmd_op,
  output logic [NUM_MOD-1:0] cmd_sel,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [DATA_W-1:0]  cmd_data,
  output logic [LEAF_W-1:0]  cmd_leaf,
  input  logic               mod_rsp_valid,
  input  logic               mod_rsp_done,
  input  logic [DATA_W-1:0]  mod_rsp_data
);
  import oram_host_pkg::*;

  localparam int CNT_W = $clog2(PROBE_MAX + 1);
  localparam int IDX_W = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1;

  seq_state_e          state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                write_q;
  logic [LEAF_W-1:0]   leaf_q;
  logic [DATA_W-1:0]   blk_q;
  logic [CNT_W-1:0]    probe_cnt_q;

  logic                accept;
  logic [LEAF_W-1:0]   table_leaf;
  logic [LEAF_W-1:0]   new_leaf;
  logic [LEAF_W-1:0]   route_leaf;
  logic [NUM_MOD-1:0]  route_sel;
  logic                relocating;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign relocating = (state_q == ST_RELOCATE);
  assign route_leaf = (state_q == ST_LOOKUP) ? table_leaf : leaf_q;

  oram_host_leaf_table #(.ADDR_W(ADDR_W), .LEAF_W(LEAF_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (accept),
    .rd_addr (req_addr),
    .rd_leaf (table_leaf),
    .wr_en   (relocating),
    .wr_addr (addr_q),
    .wr_leaf (new_leaf)
  );

  oram_host_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .LEAF_W(LEAF_W)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .step (relocating),
    .leaf (new_leaf)
  );

  oram_host_route_dec #(.NUM_MOD(NUM_MOD), .IDX_W(IDX_W)) u_dec (
    .idx (route_leaf[LEAF_W-1 -: IDX_W]),
    .sel (route_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      write_q     <= 1'b0;
      leaf_q      <= '0;
      blk_q       <= '0;
      probe_cnt_q <= '0;
      cmd_valid   <= 1'b0;
      cmd_op      <= OP_NONE;
      cmd_sel     <= '0;
      cmd_addr    <= '0;
      cmd_data    <= '0;
      cmd_leaf    <= '0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      cmd_valid <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          leaf_q      <= table_leaf;
          cmd_valid   <= 1'b1;
          cmd_op      <= write_q ? OP_START_WR : OP_START_RD;
          cmd_sel     <= route_sel;
          cmd_addr    <= addr_q;
          cmd_data    <= wdata_q;
          cmd_leaf    <= table_leaf;
          probe_cnt_q <= '0;
          state_q     <= ST_POLL;
        end
        ST_POLL: begin
          cmd_valid   <= 1'b1;
          cmd_op      <= OP_POLL;
          cmd_sel     <= route_sel;
          cmd_data    <= '0;
          probe_cnt_q <= probe_cnt_q + 1'b1;
          state_q     <= ST_WAIT_POLL;
        end
        ST_WAIT_POLL: begin
          if (mod_rsp_valid) begin
            if (mod_rsp_done) begin
              state_q <= ST_COLLECT;
            end else if (probe_cnt_q == CNT_W'(PROBE_MAX)) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_POLL;
            end
          end
        end
        ST_COLLECT: begin
          cmd_valid <= 1'b1;
          cmd_op    <= OP_COLLECT;
          cmd_sel   <= route_sel;
          state_q   <= ST_WAIT_COLLECT;
        end
        ST_WAIT_COLLECT: begin
          if (mod_rsp_valid) begin
            blk_q   <= write_q ? wdata_q : mod_rsp_data;
            state_q <= ST_RELOCATE;
          end
        end
        ST_RELOCATE: begin
          cmd_valid <= 1'b1;
          cmd_op    <= OP_RELOCATE;
          cmd_sel   <= '1;
          cmd_addr  <= addr_q;
          cmd_data  <= blk_q;
          cmd_leaf  <= new_leaf;
          rsp_valid <= 1'b1;
          rsp_rdata <= blk_q;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && req_ready |-> cmd_op == OP_RELOCATE);

  // R5
  relocate_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_RELOCATE |-> cmd_sel == '1 && rsp_valid);

  // R2
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op != OP_RELOCATE |-> $onehot(cmd_sel));

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    probe_cnt_q <= CNT_W'(PROBE_MAX));

  // R4
  good_rsp_pair_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_err |-> cmd_valid && cmd_op == OP_RELOCATE);

  // R3
  poll_same_mod_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_POLL && $past(cmd_valid) |-> $stable(cmd_sel));
endmodule

// File: tb/oram_split_host_test.sv
module oram_split_host_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [1:0]  cmd_sel;
  logic [7:0]  cmd_addr;
  logic [31:0] cmd_data;
  logic [3:0]  cmd_leaf;
  logic        mod_rsp_valid = 1'b0;
  logic        mod_rsp_done = 1'b0;
  logic [31:0] mod_rsp_data = '0;

  oram_split_host uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_leaf(cmd_leaf),
    .mod_rsp_valid(mod_rsp_valid), .mod_rsp_done(mod_rsp_done),
    .mod_rsp_data(mod_rsp_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [3:0]  leafm   [256];
  bit          touched [256];
  logic [31:0] mod_mem [256];
  logic [31:0] ref_mem [256];
  logic [7:0]  lf = 8'h01;
  int          delay = 0;
  bit          hang = 1'b0;
  int          probes = 0;
  int          relocs = 0;
  int          collects = 0;
  logic [1:0]  cur_sel = 2'b00;
  bit          cur_wr = 1'b0;
  logic [31:0] cur_wd = '0;

  function automatic logic [7:0] lstep(logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [1:0] sel_of(logic [3:0] lf4);
    return lf4[3] ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Module-side model: reacts to commands at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      mod_rsp_valid = 1'b0;
      mod_rsp_done  = 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          4'h1, 4'h9: begin
            cur_sel = sel_of(leafm[cmd_addr]);
            if (!touched[cmd_addr])
              chk(cmd_sel == cur_sel, "R1", cmd_sel, cur_sel);
            else
              chk(cmd_sel == cur_sel, "R6", cmd_sel, cur_sel);
            chk(cmd_op == (cur_wr ? 4'h9 : 4'h1), "R2", cmd_op, cur_wr ? 4'h9 : 4'h1);
            if (cur_wr) chk(cmd_data == cur_wd, "R2", cmd_data, cur_wd);
            chk(req_ready == 1'b0, "R8", req_ready, 0);
            probes = 0;
            collects = 0;
            relocs = 0;
            if (cmd_op == 4'h9) mod_mem[cmd_addr] = cmd_data;
          end
          4'h2: begin
            probes++;
            chk(cmd_sel == cur_sel, "R3", cmd_sel, cur_sel);
            chk(req_ready == 1'b0, "R8", req_ready, 0);
            mod_rsp_valid = 1'b1;
            mod_rsp_done  = !hang && (probes > delay);
          end
          4'h3: begin
            collects++;
            chk(cmd_sel == cur_sel, "R4", cmd_sel, cur_sel);
            chk(probes == delay + 1, "R3", probes, delay + 1);
            mod_rsp_valid = 1'b1;
            mod_rsp_data  = mod_mem[cmd_addr];
          end
          4'h4: begin
            relocs++;
            chk(cmd_sel == 2'b11, "R5", cmd_sel, 2'b11);
            chk(rsp_valid == 1'b1, "R5", rsp_valid, 1);
            chk(cmd_leaf == lf[3:0], "R6", cmd_leaf, lf[3:0]);
            chk(cmd_data == (cur_wr ? cur_wd : ref_mem[cmd_addr]), "R5",
                cmd_data, cur_wr ? cur_wd : ref_mem[cmd_addr]);
            leafm[cmd_addr]   = lf[3:0];
            touched[cmd_addr] = 1'b1;
            lf = lstep(lf);
          end
          default: chk(1'b0, "R2", cmd_op, 0);
        endcase
      end
    end
  end

  task automatic do_req(bit wr, logic [7:0] a, logic [31:0] d, int dly, bit hng);
    int guard;
    delay  = dly;
    hang   = hng;
    cur_wr = wr;
    cur_wd = d;
    @(negedge clk); #2;
    while (!req_ready) begin @(negedge clk); #2; end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk); #2;
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 400) begin
      @(negedge clk); #2;
      guard++;
    end
    if (guard >= 400) begin
      chk(1'b0, "R8", 0, 1);
    end else if (hng) begin
      chk(rsp_err == 1'b1, "R7", rsp_err, 1);
      chk(probes == 64, "R7", probes, 64);
      chk(relocs == 0 && collects == 0, "R7", relocs + collects, 0);
    end else begin
      chk(rsp_err == 1'b0, "R4", rsp_err, 0);
      chk(rsp_rdata == (wr ? d : ref_mem[a]), "R4", rsp_rdata, wr ? d : ref_mem[a]);
      chk(relocs == 1 && collects == 1, "R5", relocs * 16 + collects, 17);
      if (wr) ref_mem[a] = d;
    end
    hang = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      leafm[i] = 4'(i);
      touched[i] = 1'b0;
      mod_mem[i] = '0;
      ref_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    #2;
    // R9: values held during reset
    chk(req_ready == 1'b1, "R9", req_ready, 1);
    chk(cmd_valid == 1'b0, "R9", cmd_valid, 0);
    chk(rsp_valid == 1'b0, "R9", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(req_ready == 1'b1 && cmd_valid == 1'b0 && rsp_valid == 1'b0, "R9",
        {req_ready, cmd_valid, rsp_valid}, 3'b100);

    // R1/R2: first reads of unmapped addresses route by address bit 3
    for (int a = 200; a < 208; a++) do_req(1'b0, 8'(a), '0, a % 3, 1'b0);
    // Writes across a 16-address window, varied poll counts
    for (int a = 0; a < 16; a++)
      do_req(1'b1, 8'(a), 32'h0101_0101 * a ^ 32'hA5C3_0F00, a % 4, 1'b0);
    // R7: timeout leaves table and LFSR untouched
    do_req(1'b0, 8'd5, '0, 0, 1'b1);
    do_req(1'b0, 8'd5, '0, 2, 1'b0);
    // Repeated read-back passes move blocks across both halves (R6)
    for (int r = 0; r < 3; r++) begin
      for (int a = 0; a < 16; a++) do_req(1'b0, 8'(a), '0, (a + r) % 5, 1'b0);
      do_req(1'b0, 8'(r + 9), '0, 0, 1'b1);
    end
    // Rewrite then read, including the longest modelled delay
    for (int a = 0; a < 16; a += 3) begin
      do_req(1'b1, 8'(a), ~(32'h1234_0000 + 32'(a)), 63, 1'b0);
      do_req(1'b0, 8'(a), '0, 1, 1'b0);
    end
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule